// File: doc/BRIEF.md
# Core Timer with Real-Time Interrupt

This block is the free-running time base of a small microcontroller core. The bus clock goes through a fixed divide-by-four prescaler into an 8-bit counter that software may read at any time. When that counter wraps, it raises an overflow flag. Four more divider stages follow the counter. A real-time-interrupt divider comes after them and offers four periods, chosen through two rate-select bits. The selected real-time output, divided by eight again, becomes a one-cycle watchdog tick for a watchdog counter that lives outside this block.

Software reaches the block through a small register port: address, write data, write strobe and combinational read data. The control/status register holds the two event flags, their enables and the rate select. The counter register is read-only. The overflow flag and the real-time flag each clear only when software writes zero to that flag's bit. A single interrupt line is the OR of the two flags, each gated by its enable. Reset clears the whole chain, and counting starts again from zero.

Top module: `core_timer`

## Requirements
- R1: The counter register at address 0x09 returns the live 8-bit count. The count advances by one every 4 bus clocks and reads 0 just after reset.
- R2: Bit 7 of the control/status register (address 0x08) is the overflow flag. It sets on the clock edge where the 8-bit count wraps from 0xFF to 0x00, which happens once every 1024 bus clocks.
- R3: Each flag (bit 7 overflow, bit 6 real-time) clears only on a write to 0x08 that has a 0 in that flag's bit. A write with a 1 in that bit leaves the flag unchanged.
- R4: The irq output is high exactly when (bit7 AND bit5) OR (bit6 AND bit4) holds in the control/status register.
- R5: In the control/status register, bit 5 is the overflow enable, bit 4 is the real-time enable and bits 1:0 are the rate select. Bits 3:2 read as 0. Writes to 0x09 have no effect, and reads from any address other than 0x08 and 0x09 return 0.
- R6: Bit 6 (real-time flag) sets once every 16384 × 2^sel bus clocks, where sel is the rate select 0..3. Its events fall where the free-running bus-clock count since reset, plus one, is a multiple of that period.
- R7: wd_tick is a one-cycle pulse, high for one cycle once every 8 real-time periods at the current rate select (131072 bus clocks for sel=0). It coincides with a real-time flag set.
- R8: When a flag is set by hardware and cleared by a write in the same cycle, the flag ends up set.
- R9: Reset clears the counter chain, both flags, both enables, the rate select and wd_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rdata | output | 8 | Combinational read data for addr |
| irq | output | 1 | Interrupt request |
| wd_tick | output | 1 | One-cycle watchdog tick |

## Verification
A behavioural model keeps its own cycle count and is compared with the outputs on every cycle. The run passes through more than 160,000 bus clocks, so the real-time flag is seen at rate selects 0 and 1 and the watchdog tick appears at select 0. Writes alternate between ones in the flag bits, which tells a write-one-no-effect design apart from a toggle or set-on-write design, and zeros in those bits, which tests the clear path. One clearing write is placed on the exact edge where the count wraps, which separates set-wins from clear-wins priority. Writes to the counter address, reads of unused addresses and a reset in the middle of the run show whether any state leaks outside its defined path.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam logic [7:0] CSR_ADDR = 8'h08;
  localparam logic [7:0] CNT_ADDR = 8'h09;

  localparam int BIT_OVF_F  = 7;
  localparam int BIT_RTI_F  = 6;
  localparam int BIT_OVF_EN = 5;
  localparam int BIT_RTI_EN = 4;

  // True when the low n bits of v are all ones (the next increment carries out of them).
  function automatic logic low_ones(input logic [31:0] v, input int unsigned n);
    logic [31:0] m;
    m = (n >= 32) ? '1 : ((32'd1 << n) - 32'd1);
    return (v & m) == m;
  endfunction

  // Packs the control/status fields into the byte seen by software.
  function automatic logic [7:0] csr_pack(input logic ovf_f, input logic rti_f,
                                          input logic ovf_en, input logic rti_en,
                                          input logic [1:0] sel);
    logic [7:0] r;
    r = '0;
    r[BIT_OVF_F]  = ovf_f;
    r[BIT_RTI_F]  = rti_f;
    r[BIT_OVF_EN] = ovf_en;
    r[BIT_RTI_EN] = rti_en;
    r[1:0]        = sel;
    return r;
  endfunction
endpackage

// File: rtl/ct_chain.sv
module ct_chain #(
  parameter int PRE_BITS = 2,
  parameter int CNT_BITS = 8,
  parameter int MID_BITS = 4,
  parameter int SEL_W    = 2,
  parameter int WD_BITS  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    sel,
  output logic [CNT_BITS-1:0] cnt_val,
  output logic                ovf_evt,
  output logic                rti_evt,
  output logic                wd_evt
);
  localparam int NSEL     = 1 << SEL_W;
  localparam int OVF_N    = PRE_BITS + CNT_BITS;
  localparam int RTI_BASE = OVF_N + MID_BITS;
  localparam int CHAIN_W  = RTI_BASE + (NSEL - 1) + WD_BITS;

  logic [CHAIN_W-1:0] q;
  logic [NSEL-1:0]    rti_taps;
  logic [NSEL-1:0]    wd_taps;
  logic               pre_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q + 1'b1;
  end

  assign cnt_val  = q[OVF_N-1:PRE_BITS];
  assign pre_wrap = ct_pkg::low_ones(32'(q), PRE_BITS);
  assign ovf_evt  = ct_pkg::low_ones(32'(q), OVF_N);

  for (genvar k = 0; k < NSEL; k++) begin : g_tap
    assign rti_taps[k] = ct_pkg::low_ones(32'(q), RTI_BASE + k);
    assign wd_taps[k]  = ct_pkg::low_ones(32'(q), RTI_BASE + k + WD_BITS);
  end

  assign rti_evt = rti_taps[sel];
  assign wd_evt  = wd_taps[sel];

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_wrap |=> $stable(cnt_val)); // R1
  AST_OVF_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_val == '0)); // R2
  AST_WD_IN_RTI: assert property (@(posedge clk) disable iff (!rst_n)
    wd_evt |-> rti_evt); // R7
endmodule

// File: rtl/ct_flag.sv
module ct_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_req) |=> flag); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag); // R3
  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && clr_req) |=> !flag); // R3
endmodule

// File: rtl/core_timer.sv
module core_timer #(
  parameter int PRE_BITS = 2,
  parameter int CNT_BITS = 8,
  parameter int MID_BITS = 4,
  parameter int WD_BITS  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       wd_tick
);
  localparam int SEL_W = 2;

  logic [CNT_BITS-1:0] cnt_val;
  logic ovf_evt, rti_evt, wd_evt;
  logic ovf_flag, rti_flag;
  logic ovf_en, rti_en;
  logic [SEL_W-1:0] sel;
  logic csr_wr, ovf_clr, rti_clr;
  logic unused_wdata;

  assign unused_wdata = ^wdata[3:2];

  ct_chain #(
    .PRE_BITS(PRE_BITS), .CNT_BITS(CNT_BITS), .MID_BITS(MID_BITS),
    .SEL_W(SEL_W), .WD_BITS(WD_BITS)
  ) u_chain (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cnt_val(cnt_val),
    .ovf_evt(ovf_evt), .rti_evt(rti_evt), .wd_evt(wd_evt)
  );

  assign csr_wr  = wr_en && (addr == ct_pkg::CSR_ADDR);
  assign ovf_clr = csr_wr && !wdata[ct_pkg::BIT_OVF_F];
  assign rti_clr = csr_wr && !wdata[ct_pkg::BIT_RTI_F];

  ct_flag u_ovf (.clk(clk), .rst_n(rst_n), .set_evt(ovf_evt), .clr_req(ovf_clr), .flag(ovf_flag));
  ct_flag u_rti (.clk(clk), .rst_n(rst_n), .set_evt(rti_evt), .clr_req(rti_clr), .flag(rti_flag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_en  <= 1'b0;
      rti_en  <= 1'b0;
      sel     <= '0;
      wd_tick <= 1'b0;
    end else begin
      wd_tick <= wd_evt;
      if (csr_wr) begin
        ovf_en <= wdata[ct_pkg::BIT_OVF_EN];
        rti_en <= wdata[ct_pkg::BIT_RTI_EN];
        sel    <= wdata[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ct_pkg::CSR_ADDR)
      rdata = ct_pkg::csr_pack(ovf_flag, rti_flag, ovf_en, rti_en, sel);
    else if (addr == ct_pkg::CNT_ADDR)
      rdata = 8'(cnt_val);
  end

  assign irq = (ovf_flag & ovf_en) | (rti_flag & rti_en);

  AST_WD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_tick |=> !wd_tick); // R7
  AST_WD_WITH_RTI: assert property (@(posedge clk) disable iff (!rst_n)
    wd_tick |-> rti_flag); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag && !rti_flag) |-> !irq); // R4
  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr |=> ($stable(sel) && $stable(ovf_en) && $stable(rti_en))); // R5
endmodule

// File: tb/sim_core_timer.sv
`timescale 1ns/1ps
module sim_core_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic wr_en = 1'b0;
  logic [7:0] rdata;
  logic irq, wd_tick;

  int tests = 0;
  int fails = 0;

  // Reference model state
  longint m = 0;
  bit m_ovf = 0, m_rti = 0, m_oen = 0, m_ren = 0, m_wd = 0;
  int m_sel = 0;

  always #4 clk = ~clk;

  core_timer u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                 .wr_en(wr_en), .rdata(rdata), .irq(irq), .wd_tick(wd_tick));

  function automatic longint rti_period(int s);
    return longint'(16384) << s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = 0; m_ovf = 0; m_rti = 0; m_oen = 0; m_ren = 0; m_sel = 0; m_wd = 0;
    end else begin
      bit ev_o, ev_r, ev_w, wr_csr;
      ev_o = (m % 1024) == 1023;
      ev_r = (m % rti_period(m_sel)) == rti_period(m_sel) - 1;
      ev_w = (m % (rti_period(m_sel) * 8)) == rti_period(m_sel) * 8 - 1;
      wr_csr = wr_en && addr == 8'h08;
      if (ev_o) m_ovf = 1; else if (wr_csr && !wdata[7]) m_ovf = 0;
      if (ev_r) m_rti = 1; else if (wr_csr && !wdata[6]) m_rti = 0;
      if (wr_csr) begin m_oen = wdata[5]; m_ren = wdata[4]; m_sel = int'(wdata[1:0]); end
      m_wd = ev_w;
      m = m + 1;
    end
  end

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, half a period after each edge.
  always @(negedge clk) begin
    bit [7:0] csr;
    csr = {m_ovf, m_rti, m_oen, m_ren, 2'b00, 2'(m_sel)};
    if (addr == 8'h09)      check("R1 count", rdata, (m >> 2) & 255);
    else if (addr == 8'h08) begin
      check("R2 ovf flag", rdata[7], csr[7]);
      check("R6 rti flag", rdata[6], csr[6]);
      check("R5 ctrl bits", rdata[5:0], csr[5:0]);
    end else                check("R5 unmapped read", rdata, 0);
    check("R4 irq", irq, (m_ovf & m_oen) | (m_rti & m_ren));
    check("R7 wd_tick", wd_tick, m_wd);
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #2;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd_at_neg(logic [7:0] a);
    @(posedge clk); #2; addr = a;
    @(negedge clk);
  endtask

  initial begin
    #(8.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R9: reset state
    addr = 8'h09;
    repeat (3) @(negedge clk);
    check("R9 count in reset", rdata, 0);
    addr = 8'h08; #1;
    check("R9 csr in reset", rdata, 0);
    check("R9 irq in reset", irq, 0);
    @(posedge clk); #2; rst_n = 1'b1;

    // R1: count after 40 clocks is 10
    addr = 8'h09;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R1 count after 40 clocks", rdata, 10);

    // R5: write to counter address ignored
    wr(8'h09, 8'hFF);
    rd_at_neg(8'h08);
    check("R5 csr after write to 0x09", rdata, 0);
    rd_at_neg(8'h33);
    check("R5 unmapped addr", rdata, 0);

    // R2/R4: enable overflow, wait for first wrap
    wr(8'h08, 8'h20);
    addr = 8'h08;
    while (m < 1030) @(posedge clk);
    @(negedge clk);
    check("R2 ovf after wrap", rdata[7], 1);
    check("R4 irq with ovf", irq, 1);

    // R3: ones in flag bits keep flags, and bits 3:2 read 0
    wr(8'h08, 8'hEE);
    @(negedge clk);
    check("R3 ovf kept on write 1", rdata[7], 1);
    check("R5 bits 3:2 zero", rdata[3:2], 0);
    wr(8'h08, 8'h60);
    @(negedge clk);
    check("R3 ovf cleared by write 0", rdata[7], 0);
    check("R4 irq dropped", irq, 0);

    // R8: clear on the wrap edge loses to the set
    do begin @(posedge clk); #2; end while ((m % 1024) != 1023);
    addr = 8'h08; wdata = 8'h20; wr_en = 1'b1;
    @(posedge clk); #2; wr_en = 1'b0;
    @(negedge clk);
    check("R8 set wins over clear", rdata[7], 1);

    // R6/R7: real-time at sel 0 through the first watchdog tick
    wr(8'h08, 8'h10);
    while (m < 16390) @(posedge clk);
    @(negedge clk);
    check("R6 rti set at 16384", rdata[6], 1);
    check("R4 irq from rti", irq, 1);
    wr(8'h08, 8'h10);
    while (m < 131071) @(posedge clk);
    @(negedge clk);
    check("R7 wd_tick at 131072", wd_tick, 1);
    @(negedge clk);
    check("R7 wd_tick one cycle", wd_tick, 0);

    // R6: rate select 1
    wr(8'h08, 8'h11);
    while (m < 163845) @(posedge clk);
    @(negedge clk);
    check("R6 rti set at sel1", rdata[6], 1);

    // R9: reset mid-run
    @(posedge clk); #2; rst_n = 1'b0;
    @(negedge clk);
    check("R9 csr after reset", rdata, 0);
    addr = 8'h09; #1;
    check("R9 count after reset", rdata, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule